// File: doc/BRIEF.md
# ADC Reference Power-Up Sequencer

This block brings up the reference of an analog-to-digital converter in two timed steps. While a power-up request is held, it first waits a programmed time and then turns on the reference buffer. It then waits a second programmed time and turns on the reference keeper. When the keeper is on, it raises a ready flag. Dropping the request at any moment switches both enables off at once, and the sequence starts again from the beginning on the next request.

Both waits are programmed as 8-bit step counts in a configuration word, which is loaded through a simple write strobe. The length of one step in ADC clock cycles depends on the 2-bit clock-source code. One code selects the long step lengths. Every other code selects the short ones. The buffer wait and the keeper wait use different step lengths. The step length and the delay field are read at the moment each wait begins.

Top module: `adc_ref_sequencer`

## Requirements
- R1: After reset, buffer enable, keeper enable and ready are all low, and the stored configuration is zero.
- R2: A cycle with the write strobe high stores the configuration word at that clock edge. Bits 7:0 are the buffer delay step count. Bits 15:8 are the keeper delay step count. Bits 31:16 have no effect on the outputs.
- R3: With the request held and counting the first rising edge that samples the request high as edge 1, buffer enable goes high after edge Db*Mb+2, where Db is the buffer delay field and Mb is the buffer step length.
- R4: Keeper enable goes high Dk*Mk+1 rising edges after buffer enable goes high, where Dk is the keeper delay field and Mk is the keeper step length.
- R5: Clock code 1 gives Mb=64 and Mk=16. Clock code 2 gives Mb=32 and Mk=8.
- R6: Clock codes 0 and 3 use the same step lengths as code 2 (Mb=32, Mk=8).
- R7: A delay field of zero makes its wait last a single edge. With both fields zero, buffer enable rises after edge 2 and keeper enable rises after edge 3.
- R8: While the request is low, all three outputs are low in that same cycle. The next request restarts the full timing of R3 and R4.
- R9: Ready goes high together with keeper enable and stays high for as long as the request is held.
- R10: Keeper enable is never high while buffer enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word (buffer delay in bits 7:0, keeper delay in bits 15:8) |
| clk_sel | input | 2 | ADC clock-source code that sets the step lengths |
| req | input | 1 | Power-up request, held high for the whole sequence |
| buf_en | output | 1 | Reference buffer enable |
| keep_en | output | 1 | Reference keeper enable |
| ready | output | 1 | Reference is up |

## Verification
Random trials pair small delay fields with all four clock codes and random upper configuration bits. Each trial measures the edge counts to both enables. This separates the long-step code from the short-step codes, shows that the two stages use different step lengths, and shows that the upper bits are ignored. Directed runs cover both fields at zero (single-edge waits), both fields at 255 under the long-step code (the widest count), and a request dropped during each wait. The dropped-request runs show that the enables fall in the same cycle and that the next sequence restarts with its full timing.

// File: rtl/adc_ref_sequencer.sv
module adc_ref_sequencer #(
  parameter int DLY_W        = 8,
  parameter int CFG_W        = 32,
  parameter int SEL_W        = 2,
  parameter int SEL_SLOW     = 1,
  parameter int BUF_SH_SLOW  = 6,
  parameter int BUF_SH_FAST  = 5,
  parameter int KEEP_SH_SLOW = 4,
  parameter int KEEP_SH_FAST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             req,
  output logic             buf_en,
  output logic             keep_en,
  output logic             ready
);

  localparam int FIELD_W = 2 * DLY_W;
  localparam int CNT_W   = DLY_W + BUF_SH_SLOW;

  typedef enum logic [1:0] {S_IDLE, S_WAIT_BUF, S_WAIT_KEEP, S_UP} state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [FIELD_W-1:0] cfg_q;
  logic               slow;
  logic [CNT_W-1:0]   buf_load;
  logic [CNT_W-1:0]   keep_load;
  logic               unused_cfg_hi;

  assign unused_cfg_hi = ^cfg_wdata[CFG_W-1:FIELD_W];

  assign slow      = (clk_sel == SEL_W'(SEL_SLOW));
  assign buf_load  = {{(CNT_W-DLY_W){1'b0}}, cfg_q[DLY_W-1:0]}
                     << (slow ? BUF_SH_SLOW : BUF_SH_FAST);
  assign keep_load = {{(CNT_W-DLY_W){1'b0}}, cfg_q[FIELD_W-1:DLY_W]}
                     << (slow ? KEEP_SH_SLOW : KEEP_SH_FAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata[FIELD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (!req) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          st  <= S_WAIT_BUF;
          cnt <= buf_load;
        end
        S_WAIT_BUF: begin
          if (cnt == '0) begin
            st  <= S_WAIT_KEEP;
            cnt <= keep_load;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WAIT_KEEP: begin
          if (cnt == '0) st <= S_UP;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= S_UP;
      endcase
    end
  end

  assign buf_en  = req && (st == S_WAIT_KEEP || st == S_UP);
  assign keep_en = req && (st == S_UP);
  assign ready   = req && (st == S_UP);

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (st == S_IDLE && cfg_q == '0) || !$past(!rst_n) || rst_n);

  a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == $past(cfg_wdata[FIELD_W-1:0]));

  a_r3_buf_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT_BUF && req && cnt != '0) |=> cnt == CNT_W'($past(cnt) - 1'b1));

  a_r4_keep_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT_KEEP && req && cnt != '0) |=> cnt == CNT_W'($past(cnt) - 1'b1));

  a_r7_zero_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT_BUF && req && cnt == '0) |=> st == S_WAIT_KEEP);

  a_r8_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> st == S_IDLE);

  a_r9_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req) |=> (ready || !req));

  a_r10_keep_needs_buf: assert property (@(posedge clk) disable iff (!rst_n)
    keep_en |-> buf_en);

endmodule

// File: tb/adc_ref_sequencer_tb.sv
module adc_ref_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  clk_sel = 2'd1;
  logic        req = 1'b0;
  logic        buf_en, keep_en, ready;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  adc_ref_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .clk_sel(clk_sel), .req(req), .buf_en(buf_en), .keep_en(keep_en),
    .ready(ready)
  );

  function automatic int buf_mult(input logic [1:0] code);
    return (code == 2'd1) ? 64 : 32;
  endfunction

  function automatic int keep_mult(input logic [1:0] code);
    return (code == 2'd1) ? 16 : 8;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_seq(input logic [31:0] w, input logic [1:0] code, input string tag);
    int exp_b, exp_k, n, m;
    exp_b = int'(w[7:0]) * buf_mult(code) + 2;
    exp_k = int'(w[15:8]) * keep_mult(code) + 1;
    write_cfg(w);
    clk_sel = code;
    req = 1'b1;
    n = 0;
    while (n < 40000) begin
      @(posedge clk); @(negedge clk); n++;
      if (buf_en) break;
      check(!keep_en && !ready, {tag, " R10 keeper before buffer"}, keep_en, 0);
    end
    check(n == exp_b, {tag, " R3 R5 R6 R7 buffer edges"}, n, exp_b);
    m = 0;
    while (m < 40000) begin
      @(posedge clk); @(negedge clk); m++;
      if (keep_en) break;
    end
    check(m == exp_k, {tag, " R4 R5 R6 R7 keeper edges"}, m, exp_k);
    check(ready == 1'b1, {tag, " R9 ready with keeper"}, ready, 1);
    repeat (3) @(negedge clk);
    check(ready && keep_en && buf_en, {tag, " R9 ready held"}, ready, 1);
    req = 1'b0;
    #1;
    check(!buf_en && !keep_en && !ready, {tag, " R8 drop same cycle"}, buf_en, 0);
    @(negedge clk);
  endtask

  task automatic drop_during(input int wait_edges, input string tag);
    req = 1'b1;
    repeat (wait_edges) @(negedge clk);
    req = 1'b0;
    #1;
    check(!buf_en && !keep_en && !ready, {tag, " R8 outputs low on drop"}, buf_en, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(!buf_en && !keep_en && !ready, "R1 outputs low in reset", buf_en, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!buf_en && !keep_en && !ready, "R1 outputs low after reset", buf_en, 0);

    req = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(buf_en == 1'b1, "R1 R7 zero config buffer after two edges", buf_en, 1);
    req = 1'b0;
    @(negedge clk);

    write_cfg(32'h0000_0505);
    repeat (5) @(negedge clk);
    check(!buf_en && !keep_en && !ready, "R8 no request no output", buf_en, 0);

    run_seq(32'h0000_0000, 2'd1, "zero");
    run_seq(32'h0000_0503, 2'd2, "code2");
    run_seq(32'hFFFF_0201, 2'd1, "code1 R2 upper");
    run_seq(32'h1234_0102, 2'd0, "code0");
    run_seq(32'hA5A5_0301, 2'd3, "code3");
    run_seq(32'h0000_FFFF, 2'd1, "max");

    write_cfg(32'h0000_0403);
    clk_sel = 2'd2;
    drop_during(50, "mid buffer wait");
    run_seq(32'h0000_0403, 2'd2, "restart R8");
    drop_during(3 * 32 + 2 + 10, "mid keeper wait");
    run_seq(32'h0000_0403, 2'd2, "restart2 R8");

    for (int i = 0; i < 16; i++) begin
      logic [31:0] w;
      logic [1:0]  c;
      w = $urandom;
      w[7:0]  = 8'($urandom % 16);
      w[15:8] = 8'($urandom % 16);
      c = 2'($urandom % 4);
      run_seq(w, c, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule